// File: doc/BRIEF.md
# SPI Serial Boot Loader Controller

This controller runs while the processor core is held in reset. It reads a boot image from an external SPI memory over an SPI master port (mode 0). It opens the read with the read command byte 0x03 and a 24-bit start address of zero. It then streams bytes from that address onward.

The first seven image bytes form a header, parsed in this order:
- byte 0: an SCK divisor in its low nibble;
- bytes 1 to 2: a 16-bit word count, low byte first;
- bytes 3 to 6: a 32-bit reset configuration word, least significant byte first.

After byte 0 is captured, SCK changes from a slow default rate to the rate that byte selects. If the word count is nonzero, the payload that follows is copied into on-chip SRAM as 32-bit words, and the reset vector is then taken from SRAM. If the count is zero, nothing past the header is read and the vector fetch goes to external memory. The core is released only after the whole sequence has finished.

The state machine has six states:
- IDLE: the reset state. It goes to CMD after one cycle, selecting the memory.
- CMD: sends the command and address bytes. It goes to HDR after the fourth byte.
- HDR: captures the seven header bytes. After byte 6 it goes to PAY if the count is nonzero, and to CLOSE otherwise.
- PAY: packs the payload bytes into words. It goes to CLOSE when the word numbered by the count has completed.
- CLOSE: deselects the memory and settles the SRAM boot select. It goes to DONE.
- DONE: releases the core and stays there until the next reset.

Top module: `sboot_ctrl`

## Requirements
- R1: While `rst_n` is low: `core_rst_n` = 0, `done` = 0, `spi_cs_n` = 1, `spi_sck` = 0, `sram_we` = 0 and `boot_sram` = 0.
- R2: After reset the controller selects the memory and sends 0x03, 0x00, 0x00, 0x00, most significant bit first. MOSI is stable around each rising SCK edge, and SCK is low whenever `spi_cs_n` is high.
- R3: Until image byte 0 is captured, the SCK period is 2 × (DEF_DIV + 1) clock cycles. After that it is 2 × (d + 1) cycles, where d is the low nibble of byte 0. MISO is sampled on rising SCK.
- R4: `clk_div` equals the low nibble of image byte 0.
- R5: `boot_len` equals {byte 2, byte 1}.
- R6: `cfg_word` equals {byte 6, byte 5, byte 4, byte 3}.
- R7: With a count of zero, exactly 11 bytes (88 SCK rising edges) are clocked and no SRAM write occurs.
- R8: With a count N > 0, exactly N + 1 words are written, at word addresses 0 to N in order. Word k is formed from image bytes 7+4k to 10+4k, the lowest address in bits 7:0. Each write strobe lasts one cycle.
- R9: `boot_sram` is 1 exactly when the count is nonzero. It holds its final value for at least one cycle before `core_rst_n` rises.
- R10: `core_rst_n` and `done` rise in the same cycle. This happens only after the last SRAM write and after `spi_cs_n` has returned high. No SCK or write activity follows.
- R11: After release, `cfg_word`, `clk_div`, `boot_len`, `core_rst_n` and `done` hold their values until the next reset, whatever MISO does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| spi_sck | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | SPI data to memory |
| spi_miso | input | 1 | SPI data from memory |
| spi_cs_n | output | 1 | Active-low memory select |
| sram_we | output | 1 | One-cycle SRAM word write strobe |
| sram_addr | output | AW | SRAM word address |
| sram_wdata | output | 32 | SRAM write data |
| cfg_word | output | 32 | Captured reset configuration word |
| clk_div | output | 4 | Captured SCK divisor |
| boot_len | output | 16 | Captured word count |
| boot_sram | output | 1 | Reset vector served from SRAM |
| core_rst_n | output | 1 | Active-low processor reset, released at end |
| done | output | 1 | Loading sequence complete |

## Verification
Two pairs of events share a cycle.

The final SRAM write strobe lands in the same cycle that the memory is deselected. The bench provokes this with images of several word counts and divisors. Its scoreboard must hold no pending word at the moment `done` is seen, and the total count of SCK edges must match the image length exactly.

The change of SCK rate coincides with the capture of byte 0 and the launch of byte 1. The bench judges this by measuring the first SCK period at the default rate and the last period at the programmed rate.

// File: rtl/sboot_pkg.sv
`timescale 1ns/1ps
package sboot_pkg;
    // Field widths fixed by the image layout
    localparam int DIV_W     = 4;
    localparam int LEN_W     = 16;
    localparam int CFG_W     = 32;
    localparam int WORD_W    = 32;
    localparam int CMD_BYTES = 4;
    localparam int HDR_BYTES = 7;
    localparam logic [7:0] READ_OPCODE = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_HDR,
        ST_PAY,
        ST_CLOSE,
        ST_DONE
    } sboot_state_t;
endpackage

// File: rtl/sboot_spi_engine.sv
`timescale 1ns/1ps
module sboot_spi_engine #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    tx_byte,
    input  logic [DW-1:0] half_div,
    output logic          busy,
    output logic          done,
    output logic [7:0]    rx_byte,
    output logic          sck,
    output logic          mosi,
    input  logic          miso
);
    logic [DW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic [7:0]    rx_q;

    // Each SCK phase lasts half_div + 1 clock cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            sck   <= 1'b0;
            cnt_q <= '0;
            bit_q <= '0;
            sh_q  <= '0;
            rx_q  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    sh_q  <= tx_byte;
                    bit_q <= '0;
                    cnt_q <= '0;
                    sck   <= 1'b0;
                end
            end else if (cnt_q != half_div) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
                if (!sck) begin
                    sck  <= 1'b1;
                    rx_q <= {rx_q[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_q == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mosi    = sh_q[7];
    assign rx_byte = rx_q;

    AST_SCK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> busy); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
endmodule

// File: rtl/sboot_word_packer.sv
`timescale 1ns/1ps
module sboot_word_packer #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld,
    input  logic [7:0]    byte_in,
    output logic          lane_last,
    output logic          word_vld,
    output logic [31:0]   word,
    output logic [AW-1:0] word_addr
);
    logic [1:0]    lane_q;
    logic [23:0]   acc_q;
    logic [AW-1:0] next_addr_q;

    assign lane_last = (lane_q == 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q      <= '0;
            acc_q       <= '0;
            next_addr_q <= '0;
            word_vld    <= 1'b0;
            word        <= '0;
            word_addr   <= '0;
        end else begin
            word_vld <= 1'b0;
            if (byte_vld) begin
                if (lane_last) begin
                    word_vld    <= 1'b1;
                    word        <= {byte_in, acc_q};
                    word_addr   <= next_addr_q;
                    next_addr_q <= next_addr_q + 1'b1;
                    lane_q      <= '0;
                end else begin
                    unique case (lane_q)
                        2'd0:    acc_q[7:0]   <= byte_in;
                        2'd1:    acc_q[15:8]  <= byte_in;
                        default: acc_q[23:16] <= byte_in;
                    endcase
                    lane_q <= lane_q + 1'b1;
                end
            end
        end
    end

    AST_WORD_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && $past(word_vld, 1) == 1'b0 && word_addr != '0) |-> word_addr != $past(word_addr)); // R8
endmodule

// File: rtl/sboot_ctrl.sv
`timescale 1ns/1ps
module sboot_ctrl
    import sboot_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DEF_DIV = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 spi_sck,
    output logic                 spi_mosi,
    input  logic                 spi_miso,
    output logic                 spi_cs_n,
    output logic                 sram_we,
    output logic [AW-1:0]        sram_addr,
    output logic [WORD_W-1:0]    sram_wdata,
    output logic [CFG_W-1:0]     cfg_word,
    output logic [DIV_W-1:0]     clk_div,
    output logic [LEN_W-1:0]     boot_len,
    output logic                 boot_sram,
    output logic                 core_rst_n,
    output logic                 done
);
    localparam logic [DIV_W-1:0] SLOW_DIV  = DIV_W'(DEF_DIV);
    localparam logic [2:0]       CMD_LAST  = 3'(CMD_BYTES - 1);
    localparam logic [2:0]       HDR_LAST  = 3'(HDR_BYTES - 1);

    sboot_state_t     state_q, state_d;
    logic [2:0]       idx_q;
    logic             kick_q;
    logic             div_loaded_q;
    logic [LEN_W-1:0] wcnt_q;

    logic             eng_busy, eng_done;
    logic [7:0]       eng_rx, eng_tx;
    logic [DIV_W-1:0] eng_div;
    logic             lane_last, pk_vld;

    assign eng_tx  = (state_q == ST_CMD && idx_q == 3'd0) ? READ_OPCODE : 8'h00;
    assign eng_div = div_loaded_q ? clk_div : SLOW_DIV;

    sboot_spi_engine #(.DW(DIV_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (kick_q),
        .tx_byte  (eng_tx),
        .half_div (eng_div),
        .busy     (eng_busy),
        .done     (eng_done),
        .rx_byte  (eng_rx),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .miso     (spi_miso)
    );

    sboot_word_packer #(.AW(AW)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (eng_done && state_q == ST_PAY),
        .byte_in   (eng_rx),
        .lane_last (lane_last),
        .word_vld  (pk_vld),
        .word      (sram_wdata),
        .word_addr (sram_addr)
    );

    assign sram_we = pk_vld;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_CMD;
            ST_CMD:   if (eng_done && idx_q == CMD_LAST) state_d = ST_HDR;
            ST_HDR:   if (eng_done && idx_q == HDR_LAST)
                          state_d = (boot_len == '0) ? ST_CLOSE : ST_PAY;
            ST_PAY:   if (eng_done && lane_last && wcnt_q == boot_len) state_d = ST_CLOSE;
            ST_CLOSE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q        <= '0;
            kick_q       <= 1'b0;
            div_loaded_q <= 1'b0;
            wcnt_q       <= '0;
            spi_cs_n     <= 1'b1;
            cfg_word     <= '0;
            clk_div      <= '0;
            boot_len     <= '0;
            boot_sram    <= 1'b0;
            core_rst_n   <= 1'b0;
            done         <= 1'b0;
        end else begin
            kick_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    spi_cs_n <= 1'b0;
                    kick_q   <= 1'b1;
                    idx_q    <= '0;
                end
                ST_CMD: begin
                    if (eng_done) begin
                        kick_q <= 1'b1;
                        idx_q  <= (idx_q == CMD_LAST) ? 3'd0 : idx_q + 1'b1;
                    end
                end
                ST_HDR: begin
                    if (eng_done) begin
                        unique case (idx_q)
                            3'd0: begin
                                clk_div      <= eng_rx[DIV_W-1:0];
                                div_loaded_q <= 1'b1;
                            end
                            3'd1:    boot_len[7:0]   <= eng_rx;
                            3'd2:    boot_len[15:8]  <= eng_rx;
                            3'd3:    cfg_word[7:0]   <= eng_rx;
                            3'd4:    cfg_word[15:8]  <= eng_rx;
                            3'd5:    cfg_word[23:16] <= eng_rx;
                            default: cfg_word[31:24] <= eng_rx;
                        endcase
                        idx_q <= idx_q + 1'b1;
                        if (idx_q != HDR_LAST || boot_len != '0) kick_q <= 1'b1;
                    end
                end
                ST_PAY: begin
                    if (eng_done) begin
                        if (lane_last) wcnt_q <= wcnt_q + 1'b1;
                        if (!(lane_last && wcnt_q == boot_len)) kick_q <= 1'b1;
                    end
                end
                ST_CLOSE: begin
                    spi_cs_n  <= 1'b1;
                    boot_sram <= (boot_len != '0);
                end
                ST_DONE: begin
                    core_rst_n <= 1'b1;
                    done       <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_CS_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R2

    AST_NO_WRITE_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (boot_len != '0)); // R7

    AST_SEL_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> ($stable(boot_sram) && spi_cs_n)); // R9

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sram_we && !spi_sck && !eng_busy)); // R10

    AST_HOLD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_n |=> (core_rst_n && done && $stable(cfg_word) && $stable(clk_div)
                        && $stable(boot_len))); // R11
endmodule

// File: tb/tb_sboot_ctrl.sv
`timescale 1ns/1ps
module tb_sboot_ctrl;
    localparam int AW      = 16;
    localparam int DEF_DIV = 7;
    localparam int LIMIT   = 30000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spi_sck, spi_mosi, spi_cs_n;
    logic          spi_miso = 1'b0;
    logic          sram_we;
    logic [AW-1:0] sram_addr;
    logic [31:0]   sram_wdata, cfg_word;
    logic [3:0]    clk_div;
    logic [15:0]   boot_len;
    logic          boot_sram, core_rst_n, done;

    always #5 clk = ~clk;

    sboot_ctrl #(.AW(AW), .DEF_DIV(DEF_DIV)) dut (
        .clk(clk), .rst_n(rst_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
        .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .cfg_word(cfg_word), .clk_div(clk_div), .boot_len(boot_len),
        .boot_sram(boot_sram), .core_rst_n(core_rst_n), .done(done)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // SPI memory model
    logic [7:0]  img [0:63];
    int          rises = 0;
    logic [31:0] cmd_sr = '0;
    time         t_prev = 0, first_iv = 0, last_iv = 0;
    int          mk;

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            if (rises < 32) cmd_sr = {cmd_sr[30:0], spi_mosi};
            if (rises == 1) first_iv = $time - t_prev;
            else if (rises > 1) last_iv = $time - t_prev;
            t_prev = $time;
            rises++;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && rises >= 32) begin
            mk = rises - 32;
            if (mk / 8 < 64) spi_miso = img[mk / 8][7 - (mk % 8)];
            else             spi_miso = 1'b1;
        end
    end

    // Scoreboard
    typedef struct packed {
        logic [15:0] a;
        logic [31:0] d;
    } exp_t;
    exp_t exp_q [$];
    exp_t cur;
    int   writes = 0;

    always @(negedge clk) begin
        if (rst_n && sram_we) begin
            writes++;
            if (exp_q.size() == 0) begin
                check("R8", "unexpected SRAM write", 64'(sram_addr), 64'hFFFF_FFFF);
            end else begin
                cur = exp_q.pop_front();
                check("R8", "write address", 64'(sram_addr), 64'(cur.a));
                check("R8", "write data", 64'(sram_wdata), 64'(cur.d));
            end
        end
    end

    task automatic push_word(int k, logic [31:0] w);
        exp_t e;
        e.a = 16'(k);
        e.d = w;
        exp_q.push_back(e);
        img[7 + 4 * k]     = w[7:0];
        img[7 + 4 * k + 1] = w[15:8];
        img[7 + 4 * k + 2] = w[23:16];
        img[7 + 4 * k + 3] = w[31:24];
    endtask

    task automatic run(logic [3:0] dv, logic [15:0] len, logic [31:0] cfg, logic [31:0] base);
        int cyc;
        int exp_rises;
        int w0;
        for (int i = 0; i < 64; i++) img[i] = 8'hEE;
        img[0] = {4'h0, dv};
        img[1] = len[7:0];
        img[2] = len[15:8];
        img[3] = cfg[7:0];
        img[4] = cfg[15:8];
        img[5] = cfg[23:16];
        img[6] = cfg[31:24];
        exp_q.delete();
        if (len != 0)
            for (int k = 0; k <= int'(len); k++) push_word(k, base ^ (32'h0103_0507 * (k + 1)));
        rst_n = 1'b0;
        rises = 0;
        cmd_sr = '0;
        writes = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "core_rst_n in reset", 64'(core_rst_n), 64'd0);
        check("R1", "done in reset", 64'(done), 64'd0);
        check("R1", "cs_n in reset", 64'(spi_cs_n), 64'd1);
        check("R1", "sck in reset", 64'(spi_sck), 64'd0);
        check("R1", "we in reset", 64'(sram_we), 64'd0);
        check("R1", "boot_sram in reset", 64'(boot_sram), 64'd0);
        rst_n = 1'b1;
        cyc = 0;
        while (!done && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            check("R10", "watchdog: done never rose", 64'd0, 64'd1);
        end
        exp_rises = (len == 0) ? 88 : 88 + 32 * (int'(len) + 1);
        check("R2", "command and address", 64'(cmd_sr), 64'h0300_0000);
        check("R3", "header SCK period", 64'(first_iv / 10), 64'(2 * (DEF_DIV + 1)));
        check("R3", "programmed SCK period", 64'(last_iv / 10), 64'(2 * (int'(dv) + 1)));
        check("R4", "clk_div", 64'(clk_div), 64'(dv));
        check("R5", "boot_len", 64'(boot_len), 64'(len));
        check("R6", "cfg_word", 64'(cfg_word), 64'(cfg));
        if (len == 0) begin
            check("R7", "SCK edges zero length", 64'(rises), 64'(exp_rises));
            check("R7", "no SRAM writes", 64'(writes), 64'd0);
        end else begin
            check("R8", "SCK edges with payload", 64'(rises), 64'(exp_rises));
            check("R8", "word count", 64'(writes), 64'(int'(len) + 1));
        end
        check("R10", "pending words at release", 64'(exp_q.size()), 64'd0);
        check("R9", "boot_sram", 64'(boot_sram), 64'(len != 0));
        check("R10", "core_rst_n with done", 64'(core_rst_n), 64'd1);
        check("R10", "cs_n at release", 64'(spi_cs_n), 64'd1);
        // R11: toggle MISO after release and confirm nothing moves
        w0 = writes;
        for (int i = 0; i < 40; i++) begin
            spi_miso = ~spi_miso;
            @(negedge clk);
        end
        check("R11", "cfg_word held", 64'(cfg_word), 64'(cfg));
        check("R11", "clk_div held", 64'(clk_div), 64'(dv));
        check("R11", "boot_len held", 64'(boot_len), 64'(len));
        check("R11", "core_rst_n held", 64'(core_rst_n), 64'd1);
        check("R11", "done held", 64'(done), 64'd1);
        check("R10", "no writes after done", 64'(writes), 64'(w0));
        check("R10", "no SCK after done", 64'(rises), 64'(exp_rises));
    endtask

    initial begin
        run(4'd3,  16'd0, 32'hA5C3_1E77, 32'h0);
        run(4'd1,  16'd2, 32'h1234_5678, 32'hDEAD_BEEF);
        run(4'd0,  16'd5, 32'h8000_0001, 32'h0F0F_A5A5);
        run(4'd15, 16'd1, 32'hFFFF_0000, 32'h7654_3210);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(190000 * 10);
        n_fail++;
        $display("FAIL R10 global watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule